// File: doc/BRIEF.md
# Operand-Waiting Issue Pool for One Execution Unit

This block holds instructions that have left the in-order front end but cannot yet run on their execution unit. Each accepted instruction carries an operation code, the tag under which its result will later be broadcast, and two sources. A source arrives either as a finished value or as the tag of the instruction that will produce it. Naming producers by tag instead of by register removes false write-after-read and write-after-write conflicts. Only true data dependences make an instruction wait.

Every cycle, a single result bus may carry one tag and one value. Each slot compares its still-missing sources against that tag and keeps the value when they agree. The two sources of a slot fill independently of each other. Once both sources hold values, the slot can be sent to the unit. When several slots qualify, the one issued earliest goes first. A sent slot stays allocated until its own result tag appears on the bus, and is released after that. A flush empties the whole pool at once.

Top module: `rs_pool`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, no slot is occupied: `iss_ready` is 1 and `disp_valid` is 0, and later bus broadcasts of tags that flushed slots were waiting for produce no dispatch.
- R2: `iss_ready` is 0 exactly when every slot is occupied (waiting or executing). An `iss_valid` presented while `iss_ready` is 0 writes no slot.
- R3: A source tag of 0 means the accompanying value is final. A nonzero source tag names the producer, and the value bus input for that source is not used.
- R4: A slot whose source is pending on tag T takes `cdb_value` into that source in the cycle `cdb_valid` is 1 with `cdb_tag` equal to T. Each source is filled on its own, whether or not the other source is still pending.
- R5: If the bus broadcasts tag T in the same cycle an instruction with a source tag T is accepted, that source is stored as the broadcast value and is not left pending.
- R6: `disp_valid` is 1 only when some waiting slot holds values for both sources. An instruction accepted with both sources final is offered on the cycle after acceptance.
- R7: Among slots that are ready together, the slot accepted earliest is offered first, whatever its slot index.
- R8: A slot offered while `disp_ready` is 1 is sent and is never offered again. It stays occupied until the bus carries its destination tag, and is free in the following cycle.
- R9: A bus cycle with `cdb_tag` 0 changes no stored source value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties every slot in one cycle |
| iss_valid | input | 1 | Instruction offered for acceptance |
| iss_ready | output | 1 | At least one slot is free |
| iss_op | input | OP_W | Operation code |
| iss_dst_tag | input | TAG_W | Tag the result will be broadcast under (nonzero) |
| iss_a_tag | input | TAG_W | Source A producer tag, 0 when the value is final |
| iss_a_val | input | DATA_W | Source A value |
| iss_b_tag | input | TAG_W | Source B producer tag, 0 when the value is final |
| iss_b_val | input | DATA_W | Source B value |
| cdb_valid | input | 1 | Result bus carries a result this cycle |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A slot with both sources is offered to the unit |
| disp_ready | input | 1 | Unit takes the offered instruction |
| disp_op | output | OP_W | Offered operation code |
| disp_dst_tag | output | TAG_W | Offered destination tag |
| disp_a | output | DATA_W | Offered source A value |
| disp_b | output | DATA_W | Offered source B value |

## Verification
The bench makes slots become ready in an order that differs from their slot index and from their issue order. A picker that goes by index, or by the time a slot became ready, would send a younger instruction ahead of an older one. It broadcasts a producer tag in the very cycle a consumer of that tag is accepted. A design without that same-cycle check would leave the consumer stuck, and its expected dispatch would never appear. It also drives a bus cycle with tag 0. A design that compares zero tags would overwrite final sources, and wrong operand values would then show up in the dispatch stream. Finally, it fills the pool and then tries to issue into it. It also checks that a sent slot holds its place until its own tag returns, and that flushed slots stay silent when their awaited tags arrive later.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

  // Life cycle of one slot.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;

  // Tag value that marks a source as final.
  localparam int unsigned TAG_FINAL = 0;

endpackage

// File: rtl/rs_pool_slot.sv
module rs_pool_slot
  import rs_pool_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_dst,
  input  logic [TAG_W-1:0]  ld_a_tag,
  input  logic [DATA_W-1:0] ld_a_val,
  input  logic [TAG_W-1:0]  ld_b_tag,
  input  logic [DATA_W-1:0] ld_b_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              take,
  output logic              occupied,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dst,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);

  localparam logic [TAG_W-1:0] FINAL = TAG_W'(TAG_FINAL);

  // A pending tag agrees with the bus; a final tag never agrees.
  function automatic logic snoop_hit(input logic [TAG_W-1:0] pend,
                                     input logic bus_v,
                                     input logic [TAG_W-1:0] bus_t);
    return bus_v && (pend != FINAL) && (pend == bus_t);
  endfunction

  slot_state_e      state_q;
  logic [TAG_W-1:0] a_tag_q, b_tag_q;

  // Hits for the incoming sources and for the stored ones.
  logic ld_a_hit, ld_b_hit, a_hit, b_hit, own_done;

  always_comb begin
    ld_a_hit = snoop_hit(ld_a_tag, cdb_valid, cdb_tag);
    ld_b_hit = snoop_hit(ld_b_tag, cdb_valid, cdb_tag);
    a_hit    = snoop_hit(a_tag_q, cdb_valid, cdb_tag);
    b_hit    = snoop_hit(b_tag_q, cdb_valid, cdb_tag);
    own_done = snoop_hit(dst, cdb_valid, cdb_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      a_tag_q <= FINAL;
      b_tag_q <= FINAL;
      op      <= '0;
      dst     <= '0;
      a_val   <= '0;
      b_val   <= '0;
    end else if (flush) begin
      state_q <= SLOT_FREE;
      a_tag_q <= FINAL;
      b_tag_q <= FINAL;
    end else if (load) begin
      state_q <= SLOT_WAIT;
      op      <= ld_op;
      dst     <= ld_dst;
      a_tag_q <= ld_a_hit ? FINAL : ld_a_tag;
      a_val   <= ld_a_hit ? cdb_value : ld_a_val;
      b_tag_q <= ld_b_hit ? FINAL : ld_b_tag;
      b_val   <= ld_b_hit ? cdb_value : ld_b_val;
    end else begin
      unique case (state_q)
        SLOT_WAIT: begin
          if (take) state_q <= SLOT_EXEC;
          if (a_hit) begin
            a_tag_q <= FINAL;
            a_val   <= cdb_value;
          end
          if (b_hit) begin
            b_tag_q <= FINAL;
            b_val   <= cdb_value;
          end
        end
        SLOT_EXEC: if (own_done) state_q <= SLOT_FREE;
        default: state_q <= SLOT_FREE;
      endcase
    end
  end

  assign occupied = (state_q != SLOT_FREE);
  assign ready    = (state_q == SLOT_WAIT) && (a_tag_q == FINAL) && (b_tag_q == FINAL);

endmodule

// File: rtl/rs_pool_alloc.sv
module rs_pool_alloc #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0] occ_vec,
  output logic             any_free,
  output logic [N_ENT-1:0] pick_vec
);

  // One-hot mask of the lowest-index free slot.
  function automatic logic [N_ENT-1:0] lowest_free(input logic [N_ENT-1:0] occ);
    logic [N_ENT-1:0] r;
    r = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  assign pick_vec = lowest_free(occ_vec);
  assign any_free = ~&occ_vec;

endmodule

// File: rtl/rs_pool_age.sv
module rs_pool_age #(
  parameter int N_ENT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [N_ENT-1:0] alloc_vec,
  input  logic [N_ENT-1:0] ready_vec,
  output logic [N_ENT-1:0] grant_vec
);

  // older_q[i][j] set: slot i was accepted before slot j.
  logic [N_ENT-1:0][N_ENT-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (alloc_en) begin
      for (int k = 0; k < N_ENT; k++) begin
        if (alloc_vec[k]) begin
          for (int j = 0; j < N_ENT; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  // A ready slot wins when no other ready slot is older than it.
  generate
    for (genvar i = 0; i < N_ENT; i++) begin : g_sel
      logic beaten;
      always_comb begin
        beaten = 1'b0;
        for (int j = 0; j < N_ENT; j++) begin
          if (j != i && ready_vec[j] && older_q[j][i]) beaten = 1'b1;
        end
      end
      assign grant_vec[i] = ready_vec[i] && !beaten;
    end
  endgenerate

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N_ENT  = 4,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dst_tag,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [TAG_W-1:0]  disp_dst_tag,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b
);

  // Named internal events for the checker.
  logic [N_ENT-1:0] occ_vec, rdy_vec, grant_vec, pick_vec, load_vec;
  logic             issue_fire, dispatch_fire;

  logic [OP_W-1:0]   s_op  [N_ENT];
  logic [TAG_W-1:0]  s_dst [N_ENT];
  logic [DATA_W-1:0] s_a   [N_ENT];
  logic [DATA_W-1:0] s_b   [N_ENT];

  rs_pool_alloc #(.N_ENT(N_ENT)) u_alloc (
    .occ_vec  (occ_vec),
    .any_free (iss_ready),
    .pick_vec (pick_vec)
  );

  assign issue_fire    = iss_valid && iss_ready && !flush;
  assign load_vec      = pick_vec & {N_ENT{issue_fire}};
  assign disp_valid    = |grant_vec;
  assign dispatch_fire = disp_valid && disp_ready && !flush;

  rs_pool_age #(.N_ENT(N_ENT)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (issue_fire),
    .alloc_vec (pick_vec),
    .ready_vec (rdy_vec),
    .grant_vec (grant_vec)
  );

  generate
    for (genvar i = 0; i < N_ENT; i++) begin : g_slot
      rs_pool_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load      (load_vec[i]),
        .ld_op     (iss_op),
        .ld_dst    (iss_dst_tag),
        .ld_a_tag  (iss_a_tag),
        .ld_a_val  (iss_a_val),
        .ld_b_tag  (iss_b_tag),
        .ld_b_val  (iss_b_val),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .take      (dispatch_fire && grant_vec[i]),
        .occupied  (occ_vec[i]),
        .ready     (rdy_vec[i]),
        .op        (s_op[i]),
        .dst       (s_dst[i]),
        .a_val     (s_a[i]),
        .b_val     (s_b[i])
      );
    end
  endgenerate

  // One-hot OR mux of the granted slot's payload.
  always_comb begin
    disp_op      = '0;
    disp_dst_tag = '0;
    disp_a       = '0;
    disp_b       = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant_vec[i]) begin
        disp_op      = disp_op | s_op[i];
        disp_dst_tag = disp_dst_tag | s_dst[i];
        disp_a       = disp_a | s_a[i];
        disp_b       = disp_b | s_b[i];
      end
    end
  end

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N_ENT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             iss_ready,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [N_ENT-1:0] occ_vec,
  input logic [N_ENT-1:0] rdy_vec,
  input logic [N_ENT-1:0] grant_vec
);

  p_flush_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ_vec == '0));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_vec == '0) |-> !disp_valid);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |=> ($countones(occ_vec) <= $past($countones(occ_vec))));

  p_grant_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec & ~rdy_vec) == '0));

  p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_sent_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !flush) |=> ((rdy_vec & $past(grant_vec)) == '0));

endmodule

bind rs_pool rs_pool_chk #(.N_ENT(N_ENT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .iss_ready  (iss_ready),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .occ_vec    (occ_vec),
  .rdy_vec    (rdy_vec),
  .grant_vec  (grant_vec)
);

// File: tb/rs_pool_bench.sv
module rs_pool_bench;

  localparam int OP_W = 4, TAG_W = 3, DATA_W = 16;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [TAG_W-1:0]  dst;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
  } disp_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [OP_W-1:0]   iss_op = '0;
  logic [TAG_W-1:0]  iss_dst_tag = '0, iss_a_tag = '0, iss_b_tag = '0;
  logic [DATA_W-1:0] iss_a_val = '0, iss_b_val = '0;
  logic cdb_valid = 1'b0;
  logic [TAG_W-1:0]  cdb_tag = '0;
  logic [DATA_W-1:0] cdb_value = '0;
  logic disp_valid;
  logic disp_ready = 1'b0;
  logic [OP_W-1:0]   disp_op;
  logic [TAG_W-1:0]  disp_dst_tag;
  logic [DATA_W-1:0] disp_a, disp_b;

  int checks = 0;
  int errors = 0;
  disp_item_t expq[$];

  always #2 clk = ~clk;

  rs_pool u_rs_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_dst_tag(iss_dst_tag), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_dst_tag(disp_dst_tag), .disp_a(disp_a), .disp_b(disp_b)
  );

  function automatic disp_item_t mk(input int op, input int dst, input int a, input int b);
    disp_item_t it;
    it.op  = OP_W'(op);
    it.dst = TAG_W'(dst);
    it.a   = DATA_W'(a);
    it.b   = DATA_W'(b);
    return it;
  endfunction

  // Monitor: every accepted dispatch is compared with the queue head.
  always @(negedge clk) begin
    if (rst_n && disp_valid && disp_ready) begin
      disp_item_t got;
      got = {disp_op, disp_dst_tag, disp_a, disp_b};
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R6/R8 unexpected dispatch: actual %h expected none", got);
      end else begin
        disp_item_t want;
        want = expq.pop_front();
        if (got !== want) begin
          errors++;
          $display("FAIL R3/R4/R7 dispatch: actual %h expected %h", got, want);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    @(negedge clk);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_sig_ready(input string req, input int exp);
    @(negedge clk);
    checks++;
    if (int'(iss_ready) != exp) begin
      errors++;
      $display("FAIL %s iss_ready: actual %0d expected %0d", req, iss_ready, exp);
    end
  endtask

  task automatic check_sig_disp(input string req, input int exp_v, input int exp_dst);
    @(negedge clk);
    checks++;
    if (int'(disp_valid) != exp_v || (exp_v == 1 && int'(disp_dst_tag) != exp_dst)) begin
      errors++;
      $display("FAIL %s disp: actual valid %0d dst %0d expected valid %0d dst %0d",
               req, disp_valid, disp_dst_tag, exp_v, exp_dst);
    end
  endtask

  task automatic check_drained(input string req);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s pending dispatches: actual %0d expected 0", req, expq.size());
    end
  endtask

  task automatic do_issue(input int op, input int dst, input int at, input int av,
                          input int bt, input int bv);
    iss_op = OP_W'(op); iss_dst_tag = TAG_W'(dst);
    iss_a_tag = TAG_W'(at); iss_a_val = DATA_W'(av);
    iss_b_tag = TAG_W'(bt); iss_b_val = DATA_W'(bv);
    iss_valid = 1'b1;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic do_cdb(input int tag, input int val);
    cdb_valid = 1'b1; cdb_tag = TAG_W'(tag); cdb_value = DATA_W'(val);
    tick();
    cdb_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung run expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check_sig_ready("R1", 1);
    check_sig_disp("R1", 0, 0);

    // Fill the pool with waiting instructions
    do_issue(1, 1, 5, 0, 6, 0);
    do_issue(2, 2, 6, 0, 0, 16'h22);
    do_issue(3, 3, 0, 16'h33, 7, 0);
    do_issue(4, 4, 5, 0, 7, 0);
    check_sig_ready("R2 full", 0);
    // R2: issue into a full pool with final sources must not create a ready slot
    do_issue(9, 5, 0, 16'h99, 0, 16'h98);
    check_sig_disp("R2 ignored", 0, 0);

    // R4: one source filled while the other of slot 0 stays pending
    do_cdb(6, 16'h600);
    check_sig_disp("R4 partial", 1, 2);
    do_cdb(5, 16'h500);
    // R7: dst 1 accepted before dst 2, so it goes first
    check_sig_disp("R7 oldest", 1, 1);
    // R9: tag 0 broadcast must not touch any final source
    do_cdb(0, 16'hdead);
    check("R9 value kept", int'(disp_a), 16'h500);
    expq.push_back(mk(1, 1, 16'h500, 16'h600));
    expq.push_back(mk(2, 2, 16'h600, 16'h22));
    expq.push_back(mk(3, 3, 16'h33, 16'h700));
    expq.push_back(mk(4, 4, 16'h500, 16'h700));
    do_cdb(7, 16'h700);
    disp_ready = 1'b1;
    repeat (6) tick();
    check_drained("R8 drain");
    // R8: sent slots stay occupied until their tag returns
    check_sig_ready("R8 held", 0);
    do_cdb(1, 16'h1);
    check_sig_ready("R8 freed", 1);
    do_cdb(2, 0); do_cdb(3, 0); do_cdb(4, 0);

    // R5: producer broadcast in the same cycle as acceptance
    cdb_valid = 1'b1; cdb_tag = 3'd3; cdb_value = 16'h333;
    do_issue(5, 1, 3, 0, 4, 0);
    cdb_valid = 1'b0;
    expq.push_back(mk(5, 1, 16'h333, 16'h444));
    do_cdb(4, 16'h444);
    repeat (3) tick();
    check_drained("R5 bypass");
    do_cdb(1, 0);

    // R1: flush empties the pool
    disp_ready = 1'b0;
    do_issue(6, 2, 5, 0, 0, 1);
    do_issue(6, 3, 6, 0, 0, 2);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    check_sig_ready("R1 flush", 1);
    do_cdb(5, 16'h55);
    do_cdb(6, 16'h66);
    check_sig_disp("R1 flushed quiet", 0, 0);

    // R7 + R3: a younger slot at a lower index loses to an older one
    disp_ready = 1'b1;
    expq.push_back(mk(6, 1, 16'h11, 16'h12));   // R3 final sources pass unchanged
    do_issue(6, 1, 0, 16'h11, 0, 16'h12);         // slot 0
    do_issue(7, 2, 7, 16'hffff, 0, 16'h21);       // slot 1, pending
    tick();
    do_cdb(1, 0);                                 // frees slot 0
    do_issue(8, 3, 0, 16'h31, 7, 16'heeee);       // slot 0, younger
    expq.push_back(mk(7, 2, 16'h777, 16'h21));
    expq.push_back(mk(8, 3, 16'h31, 16'h777));
    do_cdb(7, 16'h777);
    repeat (4) tick();
    check_drained("R7 age over index");
    do_cdb(2, 0); do_cdb(3, 0);
    check_sig_ready("R8 all freed", 1);

    finish_run();
  end

endmodule